// File: doc/BRIEF.md
# Configuration EEPROM Checksum Sequencer

This block moves a configuration image between a word-addressed serial EEPROM command port and a local word buffer, in either direction. The port is a command/data register pair with a done bit. For every word the sequencer issues a command carrying the address, then checks the done bit at a slow, fixed interval. If done is not seen within a set number of checks, the sequencer stops and flags a timeout.

The address space has three ranges. The device-configuration words sit at addresses below `CFG_WORDS` and are summed. The checksum slot is at `CFG_WORDS`. The driver-control words occupy the rest, up to `TOTAL_WORDS-1`, and are copied without being summed.

- A read pass copies every word into the buffer and returns the 16-bit sum of the configuration words.
- A write pass first enables writing. It then stores the configuration words and puts the freshly computed sum in the checksum slot, ignoring the buffer's own value for that slot. It stores the control words next and finally disables writing.

Top module: `eep_cksum_seq`

## Requirements
- R1: After reset, busy_o, done_o and timeout_o are 0, sum_o is 0, and no command, data load or buffer write is issued until start_i is seen while idle.
- R2: A read pass issues exactly TOTAL_WORDS commands of op code 0 (read), at addresses 0 to TOTAL_WORDS-1 in ascending order. Each word returned on eep_rdata_i after completion is written to the buffer at the same address.
- R3: After a read pass, sum_o equals the 16-bit wrapping sum of the words at addresses below CFG_WORDS. The checksum slot and the control words do not contribute.
- R4: A write pass starts with a write-enable command (op code 2) and ends with a write-disable command (op code 3), for TOTAL_WORDS+2 commands in all. Each command, including these two, waits for done before the next one.
- R5: Every word write raises data_ld_o with the word on eep_wdata_o in an earlier cycle than the write command (op code 1, cmd_valid_o) that carries its address.
- R6: On a write pass, the word loaded for address CFG_WORDS is the wrapping sum of the configuration words, whatever the buffer holds there, and sum_o holds that sum at the end.
- R7: cmd_done_i is sampled once every POLL_DIV cycles, the first sample POLL_DIV cycles after the command cycle. The next command or data load follows the cycle in which done is seen.
- R8: If done is not seen within POLL_LIMIT samples, timeout_o is set, done_o pulses, and no further command is issued. timeout_o clears when the next operation is accepted.
- R9: start_i and write_i are ignored while busy_o is high.
- R10: At the end of each operation done_o is high for exactly one cycle, and busy_o is low in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start an operation (accepted while idle) |
| write_i | input | 1 | Direction: 1 writes the buffer to the EEPROM, 0 reads it |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle end-of-operation pulse |
| timeout_o | output | 1 | Last operation stopped on a done timeout |
| sum_o | output | WORD_W | Configuration-word checksum |
| cmd_valid_o | output | 1 | Command strobe to the EEPROM port |
| cmd_op_o | output | 2 | Command: 0 read, 1 write, 2 write enable, 3 write disable |
| cmd_addr_o | output | AW | Word address of the command |
| cmd_done_i | input | 1 | Done bit of the command register |
| data_ld_o | output | 1 | Load strobe for the data register |
| eep_wdata_o | output | WORD_W | Word for the data register |
| eep_rdata_i | input | WORD_W | Data register contents |
| buf_addr_o | output | AW | Buffer word address |
| buf_we_o | output | 1 | Buffer write strobe |
| buf_wdata_o | output | WORD_W | Buffer write data |
| buf_rdata_i | input | WORD_W | Buffer read data for buf_addr_o, same cycle |

## Verification
The assertions assume the following about the environment:
- start_i is a single-cycle pulse.
- cmd_done_i drops within POLL_DIV cycles of a command and stays low until that command completes.
- eep_rdata_i is valid whenever done is high after a read.
- The buffer returns data combinationally for buf_addr_o.

The bench's port model meets these assumptions. It clears done at the edge that captures a command and raises it after a programmed latency. It returns read data at capture time and keeps the buffer as a combinational-read array. Latencies are chosen to land either on the first sample or on a later one. A latency longer than the whole sampling window drives the timeout case.

// File: rtl/eep_cksum_pkg.sv
package eep_cksum_pkg;
  typedef enum logic [1:0] {
    OP_READ  = 2'd0,
    OP_WRITE = 2'd1,
    OP_WEN   = 2'd2,
    OP_WDIS  = 2'd3
  } eep_op_e;

  typedef enum logic [2:0] {
    S_IDLE, S_LOAD, S_ISSUE, S_WAIT, S_FIN
  } seq_state_e;

  typedef enum logic [1:0] {
    PH_EN, PH_WORD, PH_DIS
  } seq_phase_e;
endpackage

// File: rtl/eep_poll_timer.sv
module eep_poll_timer #(
  parameter int unsigned POLL_DIV   = 125000,
  parameter int unsigned POLL_LIMIT = 10
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  input  logic run_i,
  output logic tick_o,
  output logic last_o
);
  localparam int PW = (POLL_DIV > 1) ? $clog2(POLL_DIV) : 1;
  localparam int CW = (POLL_LIMIT > 1) ? $clog2(POLL_LIMIT) : 1;

  logic [PW-1:0] pre_q;
  logic [CW-1:0] cnt_q;

  assign tick_o = run_i && (pre_q == PW'(POLL_DIV - 1));
  assign last_o = (cnt_q == CW'(POLL_LIMIT - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q <= '0;
      cnt_q <= '0;
    end else if (clear_i) begin
      pre_q <= '0;
      cnt_q <= '0;
    end else if (run_i) begin
      if (tick_o) begin
        pre_q <= '0;
        if (!last_o) cnt_q <= cnt_q + CW'(1);
      end else begin
        pre_q <= pre_q + PW'(1);
      end
    end
  end

  a_r8_sample_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(cnt_q) < int'(POLL_LIMIT));
  a_r7_tick_spacing: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && POLL_DIV > 1) |=> !tick_o);
endmodule

// File: rtl/eep_range_dec.sv
module eep_range_dec #(
  parameter int unsigned CFG_WORDS   = 21,
  parameter int unsigned TOTAL_WORDS = 64,
  parameter int unsigned AW          = 6
) (
  input  logic [AW-1:0] addr_i,
  output logic          in_cfg_o,
  output logic          is_chk_o,
  output logic          is_last_o
);
  assign in_cfg_o  = addr_i <  AW'(CFG_WORDS);
  assign is_chk_o  = addr_i == AW'(CFG_WORDS);
  assign is_last_o = addr_i == AW'(TOTAL_WORDS - 1);
endmodule

// File: rtl/eep_sum_acc.sv
module eep_sum_acc #(
  parameter int unsigned WORD_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              add_i,
  input  logic [WORD_W-1:0] word_i,
  output logic [WORD_W-1:0] sum_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     sum_o <= '0;
    else if (clr_i)  sum_o <= '0;
    else if (add_i)  sum_o <= sum_o + word_i;
  end

  a_r3_clear_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (sum_o == '0));
  a_r3_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && !add_i) |=> $stable(sum_o));
endmodule

// File: rtl/eep_cksum_seq.sv
module eep_cksum_seq
  import eep_cksum_pkg::*;
#(
  parameter int unsigned WORD_W      = 16,
  parameter int unsigned CFG_WORDS   = 21,
  parameter int unsigned TOTAL_WORDS = 64,
  parameter int unsigned POLL_DIV    = 125000,
  parameter int unsigned POLL_LIMIT  = 10,
  localparam int unsigned AW         = $clog2(TOTAL_WORDS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              write_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              timeout_o,
  output logic [WORD_W-1:0] sum_o,
  output logic              cmd_valid_o,
  output logic [1:0]        cmd_op_o,
  output logic [AW-1:0]     cmd_addr_o,
  input  logic              cmd_done_i,
  output logic              data_ld_o,
  output logic [WORD_W-1:0] eep_wdata_o,
  input  logic [WORD_W-1:0] eep_rdata_i,
  output logic [AW-1:0]     buf_addr_o,
  output logic              buf_we_o,
  output logic [WORD_W-1:0] buf_wdata_o,
  input  logic [WORD_W-1:0] buf_rdata_i
);
  seq_state_e  state_q;
  seq_phase_e  phase_q;
  logic        wr_q;
  logic        timeout_q;
  logic [AW-1:0] addr_q;

  logic in_cfg, is_chk, is_last;
  logic tick, last_poll;
  logic poll_ok, poll_fail, word_done;
  logic acc_clr, acc_add;
  logic [WORD_W-1:0] acc_word;
  eep_op_e op;

  eep_range_dec #(
    .CFG_WORDS(CFG_WORDS), .TOTAL_WORDS(TOTAL_WORDS), .AW(AW)
  ) u_dec (
    .addr_i(addr_q), .in_cfg_o(in_cfg), .is_chk_o(is_chk), .is_last_o(is_last)
  );

  eep_poll_timer #(.POLL_DIV(POLL_DIV), .POLL_LIMIT(POLL_LIMIT)) u_tmr (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .clear_i(state_q == S_ISSUE), .run_i(state_q == S_WAIT),
    .tick_o(tick), .last_o(last_poll)
  );

  assign poll_ok   = tick && cmd_done_i;
  assign poll_fail = tick && !cmd_done_i && last_poll;
  assign word_done = poll_ok && (phase_q == PH_WORD);

  // sum: reads add on completion, writes add when the word is loaded
  assign acc_clr  = (state_q == S_IDLE) && start_i;
  assign acc_add  = in_cfg && ((word_done && !wr_q) || (state_q == S_LOAD));
  assign acc_word = wr_q ? buf_rdata_i : eep_rdata_i;

  eep_sum_acc #(.WORD_W(WORD_W)) u_sum (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(acc_clr), .add_i(acc_add),
    .word_i(acc_word), .sum_o(sum_o)
  );

  always_comb begin
    unique case (phase_q)
      PH_EN:   op = OP_WEN;
      PH_DIS:  op = OP_WDIS;
      default: op = wr_q ? OP_WRITE : OP_READ;
    endcase
  end

  assign cmd_valid_o = (state_q == S_ISSUE);
  assign cmd_op_o    = op;
  assign cmd_addr_o  = addr_q;
  assign data_ld_o   = (state_q == S_LOAD);
  assign eep_wdata_o = is_chk ? sum_o : buf_rdata_i;
  assign buf_addr_o  = addr_q;
  assign buf_we_o    = word_done && !wr_q;
  assign buf_wdata_o = eep_rdata_i;
  assign busy_o      = (state_q != S_IDLE);
  assign done_o      = (state_q == S_FIN);
  assign timeout_o   = timeout_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= S_IDLE;
      phase_q   <= PH_WORD;
      wr_q      <= 1'b0;
      timeout_q <= 1'b0;
      addr_q    <= '0;
    end else begin
      unique case (state_q)
        S_IDLE: if (start_i) begin
          wr_q      <= write_i;
          addr_q    <= '0;
          timeout_q <= 1'b0;
          phase_q   <= write_i ? PH_EN : PH_WORD;
          state_q   <= S_ISSUE;
        end
        S_LOAD:  state_q <= S_ISSUE;
        S_ISSUE: state_q <= S_WAIT;
        S_WAIT: begin
          if (poll_ok) begin
            unique case (phase_q)
              PH_EN: begin
                phase_q <= PH_WORD;
                state_q <= S_LOAD;
              end
              PH_WORD: begin
                if (is_last) begin
                  if (wr_q) begin
                    phase_q <= PH_DIS;
                    state_q <= S_ISSUE;
                  end else begin
                    state_q <= S_FIN;
                  end
                end else begin
                  addr_q  <= addr_q + AW'(1);
                  state_q <= wr_q ? S_LOAD : S_ISSUE;
                end
              end
              default: state_q <= S_FIN;
            endcase
          end else if (poll_fail) begin
            timeout_q <= 1'b1;
            state_q   <= S_FIN;
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  a_r5_load_before_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_o && cmd_op_o == 2'd1) |-> $past(data_ld_o));
  a_r2_strobes_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({cmd_valid_o, data_ld_o, buf_we_o}));
  a_r8_quiet_after_timeout: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timeout_o |-> !(cmd_valid_o || data_ld_o || buf_we_o));
  a_r10_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> (!done_o && !busy_o));
  a_r9_dir_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o)) |-> $stable(wr_q));
  a_r1_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !(cmd_valid_o || data_ld_o || buf_we_o));
endmodule

// File: tb/sim_eep_cksum_seq.sv
module sim_eep_cksum_seq;
  localparam int CFG = 6;
  localparam int TOT = 12;
  localparam int DIV = 4;
  localparam int LIM = 6;
  localparam int AW  = $clog2(TOT);

  // [31] write, [30:23] latency, [22] all-ones words, [15:0] seed
  localparam logic [31:0] VEC [5] = '{
    {1'b0, 8'd2, 1'b0, 6'd0, 16'h1234},
    {1'b0, 8'd6, 1'b0, 6'd0, 16'h0BEE},
    {1'b1, 8'd1, 1'b0, 6'd0, 16'h5555},
    {1'b1, 8'd5, 1'b1, 6'd0, 16'h0000},
    {1'b0, 8'd3, 1'b1, 6'd0, 16'h0000}
  };

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic start_i = 1'b0, write_i = 1'b0;
  logic busy_o, done_o, timeout_o;
  logic [15:0] sum_o;
  logic cmd_valid_o, data_ld_o, buf_we_o;
  logic [1:0] cmd_op_o;
  logic [AW-1:0] cmd_addr_o, buf_addr_o;
  logic [15:0] eep_wdata_o, buf_wdata_o, buf_rdata_i;
  logic cmd_done_i = 1'b1;
  logic [15:0] eep_rdata_i = '0;

  always #4 clk_i = ~clk_i;

  eep_cksum_seq #(.WORD_W(16), .CFG_WORDS(CFG), .TOTAL_WORDS(TOT),
                  .POLL_DIV(DIV), .POLL_LIMIT(LIM)) u0 (.*);

  logic [15:0] eemem [TOT];
  logic [15:0] bufm  [TOT];
  logic [15:0] dreg = '0;
  logic [7:0]  lat_r = 8'd2;
  logic [7:0]  lat_cnt = '0;
  int cmd_n = 0;
  int cyc = 0;
  logic [1:0]    log_op   [512];
  logic [AW-1:0] log_addr [512];
  logic [15:0]   log_dat  [512];
  int            log_cyc  [512];
  int n_chk = 0, n_fail = 0;

  assign buf_rdata_i = bufm[buf_addr_o];

  always @(posedge clk_i) begin
    cyc <= cyc + 1;
    if (cmd_valid_o) begin
      log_op[cmd_n]   <= cmd_op_o;
      log_addr[cmd_n] <= cmd_addr_o;
      log_dat[cmd_n]  <= dreg;
      log_cyc[cmd_n]  <= cyc;
      cmd_n   <= cmd_n + 1;
      cmd_done_i <= 1'b0;
      lat_cnt <= lat_r;
      if (cmd_op_o == 2'd1) eemem[cmd_addr_o] <= dreg;
      if (cmd_op_o == 2'd0) eep_rdata_i <= eemem[cmd_addr_o];
    end else if (lat_cnt != 0) begin
      lat_cnt <= lat_cnt - 8'd1;
      if (lat_cnt == 8'd1) cmd_done_i <= 1'b1;
    end
    if (data_ld_o) dreg <= eep_wdata_o;
    if (buf_we_o) bufm[buf_addr_o] <= buf_wdata_o;
  end

  function automatic logic [15:0] pat(input logic ones, input logic [15:0] seed, input int a);
    if (ones) return 16'hFFFF;
    return 16'(seed * 16'd40503 + 16'(a) * 16'd9973) ^ 16'(a << 9);
  endfunction

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic start_op(input logic wr);
    @(negedge clk_i);
    start_i = 1'b1; write_i = wr;
    @(negedge clk_i);
    start_i = 1'b0; write_i = 1'b0;
  endtask

  task automatic wait_done();
    int i;
    for (i = 0; i < 4000 && !done_o; i++) @(negedge clk_i);
    check(done_o, "R10 done seen (watchdog)", done_o, 1);
    @(negedge clk_i);
    check(!done_o && !busy_o, "R10 single pulse then idle", {done_o, busy_o}, 0);
  endtask

  task automatic fill(input logic wr, input logic ones, input logic [15:0] seed);
    for (int a = 0; a < TOT; a++) begin
      if (wr) begin bufm[a] = pat(ones, seed, a); eemem[a] = '0; end
      else    begin eemem[a] = pat(ones, seed, a); bufm[a] = '0; end
    end
    if (wr) bufm[CFG] = 16'hDEAD;
  endtask

  task automatic verify_read(input int base, input int lat, input logic chk_gap);
    logic [15:0] exp_sum = '0;
    logic ok = 1'b1, gok = 1'b1, bok = 1'b1;
    int gap = ((lat + DIV) / DIV) * DIV + 1;
    for (int a = 0; a < CFG; a++) exp_sum += eemem[a];
    check(cmd_n - base == TOT, "R2 read command count", cmd_n - base, TOT);
    for (int i = 0; i < TOT; i++) begin
      if (log_op[base+i] != 2'd0 || int'(log_addr[base+i]) != i) ok = 1'b0;
      if (bufm[i] != eemem[i]) bok = 1'b0;
      if (i > 0 && log_cyc[base+i] - log_cyc[base+i-1] != gap) gok = 1'b0;
    end
    check(ok, "R2 read ops ascending", ok, 1);
    check(bok, "R2 buffer matches eeprom", bok, 1);
    check(sum_o == exp_sum, "R3 read checksum", sum_o, exp_sum);
    if (chk_gap) check(gok, "R7 poll spacing", log_cyc[base+1] - log_cyc[base], gap);
    check(!timeout_o, "R8 no timeout", timeout_o, 0);
  endtask

  task automatic verify_write(input int base);
    logic [15:0] exp_sum = '0;
    logic ok = 1'b1, dok = 1'b1;
    for (int a = 0; a < CFG; a++) exp_sum += bufm[a];
    check(cmd_n - base == TOT + 2, "R4 write command count", cmd_n - base, TOT + 2);
    check(log_op[base] == 2'd2, "R4 write enable first", log_op[base], 2);
    check(log_op[base+TOT+1] == 2'd3, "R4 write disable last", log_op[base+TOT+1], 3);
    for (int i = 0; i < TOT; i++) begin
      if (log_op[base+1+i] != 2'd1 || int'(log_addr[base+1+i]) != i) ok = 1'b0;
      if (i != CFG && log_dat[base+1+i] != bufm[i]) dok = 1'b0;
      if (i != CFG && eemem[i] != bufm[i]) dok = 1'b0;
    end
    check(ok, "R5 write ops ascending", ok, 1);
    check(dok, "R5 data loaded before each write", dok, 1);
    check(eemem[CFG] == exp_sum, "R6 checksum slot stored", eemem[CFG], exp_sum);
    check(sum_o == exp_sum, "R6 sum_o after write", sum_o, exp_sum);
  endtask

  initial begin
    int base;
    fill(1'b0, 1'b0, 16'h0001);
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk_i);
    check(!busy_o && !done_o && !timeout_o && sum_o == 0 && cmd_n == 0,
          "R1 reset state", {busy_o, done_o, timeout_o, sum_o}, 0);

    foreach (VEC[v]) begin
      fill(VEC[v][31], VEC[v][22], VEC[v][15:0]);
      lat_r = VEC[v][30:23];
      base = cmd_n;
      start_op(VEC[v][31]);
      wait_done();
      if (VEC[v][31]) verify_write(base);
      else            verify_read(base, int'(VEC[v][30:23]), 1'b1);
    end

    // R8: done never arrives within the sampling window
    fill(1'b0, 1'b0, 16'h7777);
    lat_r = 8'd255;
    base = cmd_n;
    start_op(1'b0);
    wait_done();
    check(timeout_o, "R8 timeout flagged", timeout_o, 1);
    repeat (20) @(negedge clk_i);
    check(cmd_n - base == 1, "R8 no command after timeout", cmd_n - base, 1);

    // R8 recovery: flag clears on the next accepted start
    lat_r = 8'd2;
    base = cmd_n;
    start_op(1'b0);
    check(!timeout_o, "R8 timeout cleared on start", timeout_o, 0);
    wait_done();
    verify_read(base, 2, 1'b1);

    // R9: a second start while busy is ignored
    fill(1'b0, 1'b0, 16'h2468);
    base = cmd_n;
    start_op(1'b0);
    repeat (10) @(negedge clk_i);
    start_i = 1'b1; write_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0; write_i = 1'b0;
    wait_done();
    verify_read(base, 2, 1'b0);
    repeat (5) @(negedge clk_i);
    check(cmd_n - base == TOT && !busy_o, "R9 start ignored while busy", cmd_n - base, TOT);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    n_chk++; n_fail++;
    $display("FAIL R10 global watchdog actual=%0h expected=%0h", cyc, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule